// File: doc/BRIEF.md
# Programmable Peripheral Bring-Up Sequencer

This block brings an external peripheral chip out of power-on by running a short program held in an on-chip constant ROM. A `start` pulse makes the sequencer fetch instruction words from address zero upward and execute each one in turn. An instruction either holds the peripheral in reset for a programmed number of clocks, writes one byte to one peripheral register through an active-low write strobe, or stops the run and raises `done`.

Each instruction takes a fetch cycle (the registered ROM read) and a decode cycle before execution starts. Throughput is irrelevant because the sequence runs rarely. The strobe's low and high widths come from nanosecond parameters and the clock period, rounded up to whole clocks. A different bring-up sequence needs only a different `PROGRAM` parameter, and the control logic stays as it is. A long reset hold, such as 20 ms, is reached through a per-unit clock multiplier, `RST_TICK`.

Top module: `init_seq_ctrl`

## Requirements
- R1: After synchronous reset, `busy`=0, `done`=0, `periph_rst`=0 and `wr_n`=1, and these values hold until `start` is seen.
- R2: A `start` pulse while idle sets `busy` on the next clock edge and begins execution at ROM word 0. A `start` while `busy` is 1 is ignored.
- R3: An instruction word is 18 bits. Bits [17:16] are the opcode: 01 = reset hold, 10 = register write, and 00 or 11 = stop. For a write, bits [15:8] are the register address and bits [7:0] are the data. For a reset hold, bits [15:0] are the duration.
- R4: A reset-hold instruction drives `periph_rst` high for exactly duration×`RST_TICK` consecutive clocks. A duration of 0 produces no pulse.
- R5: A write instruction drives `reg_addr` and `reg_data` and holds `wr_n` low for exactly ceil(`WR_LOW_NS`/`CLK_NS`) clocks. Address and data do not change while `wr_n` is low.
- R6: After each write, `wr_n` stays high for at least ceil(`WR_HIGH_NS`/`CLK_NS`) clocks before any later write strobe falls.
- R7: A stop instruction sets `done`=1 and `busy`=0. ROM words after it are never executed.
- R8: Instructions run once each, in ROM address order.
- R9: A `start` while `done`=1 clears `done` and runs the program again from word 0.
- R10: `periph_rst` is high only while a reset-hold instruction executes, and it is never high while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle pulse that starts the program |
| periph_rst | output | 1 | Active-high reset to the peripheral |
| reg_addr | output | 8 | Peripheral register address |
| reg_data | output | 8 | Peripheral register write data |
| wr_n | output | 1 | Active-low write strobe |
| busy | output | 1 | High while the program runs |
| done | output | 1 | High after a stop instruction until the next start |

## Verification
The hardest situation to reach from the ports is a `start` that arrives in the middle of a run. A sequencer that honoured it would still look correct in a quick check, because the same writes would appear. The bench therefore pulses `start` during the first reset hold and then checks the exact count, lengths and order of every reset pulse and every write. Its test program also has a zero-length reset hold, which must leave no trace, and a write placed after the stop word, which must never reach the pins. A second run, started from the `done` state, checks that the program restarts cleanly from word 0.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;

  localparam int WORD_W = 18;

  typedef enum logic [1:0] {
    OP_HALT  = 2'b00,
    OP_RESET = 2'b01,
    OP_WRITE = 2'b10,
    OP_STOP  = 2'b11
  } opcode_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_DECODE,
    S_RUN_RST,
    S_RUN_WR,
    S_DONE
  } seq_state_t;

  // Default bring-up program: 20000 units of reset hold, three register writes, stop.
  localparam int DEF_PROG_LEN = 8;
  localparam logic [DEF_PROG_LEN*WORD_W-1:0] DEF_PROGRAM = {
    {2'b00, 16'h0000},
    {2'b00, 16'h0000},
    {2'b00, 16'h0000},
    {2'b11, 16'h0000},
    {2'b10, 8'h03, 8'hC4},
    {2'b10, 8'h02, 8'h0F},
    {2'b10, 8'h01, 8'h80},
    {2'b01, 16'd20000}
  };

endpackage

// File: rtl/init_seq_rom.sv
module init_seq_rom #(
  parameter int W = 18,
  parameter int DEPTH = 8,
  parameter logic [W*DEPTH-1:0] CONTENTS = '0,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [W-1:0]  q
);

  logic [W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign mem[i] = CONTENTS[i*W +: W];
  end

  // Registered read: this is the fetch cycle.
  always_ff @(posedge clk) begin
    q <= mem[addr];
  end

endmodule

// File: rtl/init_seq_hold_timer.sv
module init_seq_hold_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [CNT_W-1:0] load,
  output logic             active,
  output logic             fin
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      fin    <= 1'b0;
      cnt    <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        if (load == '0) begin
          fin <= 1'b1;
        end else begin
          active <= 1'b1;
          cnt    <= load;
        end
      end else if (active) begin
        if (cnt == CNT_W'(1)) begin
          active <= 1'b0;
          fin    <= 1'b1;
          cnt    <= '0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R4: the hold output never stays on with an exhausted count
  assert_active_has_count_R4: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt != '0));

  // R4: a completion pulse lasts one cycle
  assert_fin_single_R4: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin);

endmodule

// File: rtl/init_seq_strobe.sv
module init_seq_strobe #(
  parameter int LOW_CLKS = 6,
  parameter int HIGH_CLKS = 10,
  localparam int MAXC = (LOW_CLKS > HIGH_CLKS) ? LOW_CLKS : HIGH_CLKS,
  localparam int CW = $clog2(MAXC + 1) + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic wr_n,
  output logic fin
);

  logic          running;
  logic          in_low;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_n    <= 1'b1;
      fin     <= 1'b0;
      running <= 1'b0;
      in_low  <= 1'b0;
      cnt     <= '0;
    end else begin
      fin <= 1'b0;
      if (go && !running) begin
        wr_n    <= 1'b0;
        running <= 1'b1;
        in_low  <= 1'b1;
        cnt     <= CW'(LOW_CLKS);
      end else if (running) begin
        if (cnt == CW'(1)) begin
          if (in_low) begin
            wr_n   <= 1'b1;
            in_low <= 1'b0;
            cnt    <= CW'(HIGH_CLKS);
          end else begin
            running <= 1'b0;
            fin     <= 1'b1;
            cnt     <= '0;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // Observation counters for the timing checks below
  logic [CW-1:0] low_run;
  logic [CW-1:0] high_run;
  logic          seen_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run  <= '0;
      high_run <= '0;
      seen_low <= 1'b0;
    end else begin
      if (!wr_n) begin
        seen_low <= 1'b1;
        if (low_run != '1) low_run <= low_run + 1'b1;
        high_run <= '0;
      end else begin
        low_run <= '0;
        if (high_run != '1) high_run <= high_run + 1'b1;
      end
    end
  end

  // R5: strobe low for exactly the rounded-up low count
  assert_low_width_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_n && $past(!wr_n)) |-> (low_run == CW'(LOW_CLKS)));

  // R6: strobe recovery time before the next falling edge
  assert_high_gap_R6: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && $past(wr_n) && seen_low) |-> (high_run >= CW'(HIGH_CLKS)));

endmodule

// File: rtl/init_seq_ctrl.sv
module init_seq_ctrl
  import init_seq_pkg::*;
#(
  parameter int CLK_NS = 10,
  parameter int WR_LOW_NS = 60,
  parameter int WR_HIGH_NS = 100,
  parameter int RST_TICK = 100,
  parameter int PROG_LEN = DEF_PROG_LEN,
  parameter logic [PROG_LEN*WORD_W-1:0] PROGRAM = DEF_PROGRAM
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output logic       periph_rst,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_data,
  output logic       wr_n,
  output logic       busy,
  output logic       done
);

  localparam int LOW_RAW  = (WR_LOW_NS + CLK_NS - 1) / CLK_NS;
  localparam int HIGH_RAW = (WR_HIGH_NS + CLK_NS - 1) / CLK_NS;
  localparam int LOW_CLKS  = (LOW_RAW < 1) ? 1 : LOW_RAW;
  localparam int HIGH_CLKS = (HIGH_RAW < 1) ? 1 : HIGH_RAW;
  localparam int PC_W  = (PROG_LEN > 1) ? $clog2(PROG_LEN) : 1;
  localparam int CNT_W = 16 + $clog2(RST_TICK + 1);
  localparam logic [PC_W-1:0] LAST_PC = PC_W'(PROG_LEN - 1);

  seq_state_t        st;
  logic [PC_W-1:0]   pc;
  logic [WORD_W-1:0] word;
  opcode_t           op;
  logic              tmr_go;
  logic              tmr_fin;
  logic              stb_go;
  logic              stb_fin;
  logic [CNT_W-1:0]  hold_len;

  init_seq_rom #(.W(WORD_W), .DEPTH(PROG_LEN), .CONTENTS(PROGRAM)) u_rom (
    .clk (clk),
    .addr(pc),
    .q   (word)
  );

  assign op       = opcode_t'(word[17:16]);
  assign hold_len = CNT_W'(word[15:0]) * CNT_W'(RST_TICK);
  assign tmr_go   = (st == S_DECODE) && (op == OP_RESET);
  assign stb_go   = (st == S_DECODE) && (op == OP_WRITE);

  init_seq_hold_timer #(.CNT_W(CNT_W)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .go    (tmr_go),
    .load  (hold_len),
    .active(periph_rst),
    .fin   (tmr_fin)
  );

  init_seq_strobe #(.LOW_CLKS(LOW_CLKS), .HIGH_CLKS(HIGH_CLKS)) u_strobe (
    .clk (clk),
    .rst (rst),
    .go  (stb_go),
    .wr_n(wr_n),
    .fin (stb_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      pc       <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      reg_addr <= '0;
      reg_data <= '0;
    end else begin
      unique case (st)
        S_IDLE, S_DONE: begin
          if (start) begin
            pc   <= '0;
            busy <= 1'b1;
            done <= 1'b0;
            st   <= S_FETCH;
          end
        end
        S_FETCH: st <= S_DECODE;
        S_DECODE: begin
          case (op)
            OP_RESET: st <= S_RUN_RST;
            OP_WRITE: begin
              reg_addr <= word[15:8];
              reg_data <= word[7:0];
              st       <= S_RUN_WR;
            end
            default: begin
              st   <= S_DONE;
              done <= 1'b1;
              busy <= 1'b0;
            end
          endcase
        end
        S_RUN_RST, S_RUN_WR: begin
          if ((st == S_RUN_RST && tmr_fin) || (st == S_RUN_WR && stb_fin)) begin
            if (pc == LAST_PC) begin
              st   <= S_DONE;
              done <= 1'b1;
              busy <= 1'b0;
            end else begin
              pc <= pc + 1'b1;
              st <= S_FETCH;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5: address and data held while the strobe is low
  assert_bus_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && $past(!wr_n)) |-> ($stable(reg_addr) && $stable(reg_data)));

  // R10: peripheral reset only during a reset-hold instruction
  assert_rst_only_in_hold_R10: assert property (@(posedge clk) disable iff (rst)
    periph_rst |-> (busy && st == S_RUN_RST));

  // R7: finished means not busy and the bus quiet
  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && wr_n && !periph_rst));

  // R2: a start while running does not move the program pointer back
  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && start && st != S_RUN_RST && st != S_RUN_WR) |=> (st != S_FETCH || pc == $past(pc)));

  // R5: the strobe falls only while a write executes
  assert_strobe_in_write_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> (st == S_RUN_WR));

endmodule

// File: tb/sim_init_seq_ctrl.sv
`timescale 1ns/1ps
module sim_init_seq_ctrl;

  localparam int CLK_PERIOD = 20;
  localparam int LOW_EXP = 3;   // ceil(50/20)
  localparam int HIGH_EXP = 5;  // ceil(100/20)
  localparam int TICK = 4;

  localparam logic [8*18-1:0] TB_PROG = {
    {2'b10, 8'h55, 8'h55},   // after stop: must never run
    {2'b11, 16'h0000},       // stop
    {2'b10, 8'hFF, 8'h00},
    {2'b01, 16'd2},          // 8 clocks
    {2'b01, 16'd0},          // no pulse
    {2'b10, 8'hA0, 8'h5F},
    {2'b10, 8'h12, 8'h34},
    {2'b01, 16'd5}           // 20 clocks
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic periph_rst, wr_n, busy, done;
  logic [7:0] reg_addr, reg_data;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  init_seq_ctrl #(
    .CLK_NS(20), .WR_LOW_NS(50), .WR_HIGH_NS(100), .RST_TICK(TICK),
    .PROG_LEN(8), .PROGRAM(TB_PROG)
  ) u0 (
    .clk(clk), .rst(rst), .start(start), .periph_rst(periph_rst),
    .reg_addr(reg_addr), .reg_data(reg_data), .wr_n(wr_n),
    .busy(busy), .done(done)
  );

  // Monitor, sampled on the falling edge
  int cyc = 0;
  int rcur = 0, nr = 0, wcur = 0, nw = 0;
  int rst_len [8];
  int wr_len [8];
  logic [7:0] wa [8];
  logic [7:0] wd [8];
  int unstable = 0, rst_idle = 0, min_gap = 1000, last_rise = 0;
  bit have_rise = 0;
  int first_rst_end = -1, first_wr = -1;

  always @(negedge clk) begin
    cyc++;
    if (periph_rst) rcur++;
    else if (rcur > 0) begin
      if (nr < 8) rst_len[nr] = rcur;
      if (first_rst_end < 0) first_rst_end = cyc;
      nr++;
      rcur = 0;
    end
    if (periph_rst && !busy) rst_idle++;
    if (!wr_n) begin
      if (wcur == 0) begin
        if (nw < 8) begin wa[nw] = reg_addr; wd[nw] = reg_data; end
        if (first_wr < 0) first_wr = cyc;
        if (have_rise && (cyc - last_rise) < min_gap) min_gap = cyc - last_rise;
      end else if (nw < 8 && (reg_addr != wa[nw] || reg_data != wd[nw])) unstable++;
      wcur++;
    end else if (wcur > 0) begin
      if (nw < 8) wr_len[nw] = wcur;
      nw++;
      wcur = 0;
      last_rise = cyc;
      have_rise = 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_monitor();
    @(posedge clk); #1;
    rcur = 0; nr = 0; wcur = 0; nw = 0; unstable = 0; rst_idle = 0;
    min_gap = 1000; have_rise = 0; first_rst_end = -1; first_wr = -1;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
  endtask

  // R1: idle values after reset and with no start
  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (30) @(negedge clk);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(periph_rst == 1'b0, "R1 periph_rst", periph_rst, 0);
    check(wr_n == 1'b1, "R1 wr_n", wr_n, 1);
  endtask

  // R3 R4 R5 R6 R7 R8 R10: full program outcome
  task automatic check_run(input string tag);
    check(done == 1'b1, {tag, " R7 done"}, done, 1);
    check(busy == 1'b0, {tag, " R7 busy"}, busy, 0);
    repeat (40) @(negedge clk);
    check(nr == 2, {tag, " R4 pulse count"}, nr, 2);
    check(rst_len[0] == 5*TICK, {tag, " R4 first hold"}, rst_len[0], 5*TICK);
    check(rst_len[1] == 2*TICK, {tag, " R4 second hold"}, rst_len[1], 2*TICK);
    check(nw == 3, {tag, " R7 write count"}, nw, 3);
    check(wa[0] == 8'h12 && wd[0] == 8'h34, {tag, " R3 write0"}, {wa[0], wd[0]}, 16'h1234);
    check(wa[1] == 8'hA0 && wd[1] == 8'h5F, {tag, " R8 write1"}, {wa[1], wd[1]}, 16'hA05F);
    check(wa[2] == 8'hFF && wd[2] == 8'h00, {tag, " R8 write2"}, {wa[2], wd[2]}, 16'hFF00);
    for (int i = 0; i < 3; i++)
      check(wr_len[i] == LOW_EXP, {tag, " R5 low width"}, wr_len[i], LOW_EXP);
    check(unstable == 0, {tag, " R5 bus stability"}, unstable, 0);
    check(min_gap >= HIGH_EXP, {tag, " R6 high gap"}, min_gap, HIGH_EXP);
    check(first_rst_end >= 0 && first_rst_end < first_wr, {tag, " R8 order"}, first_rst_end, first_wr);
    check(rst_idle == 0, {tag, " R10 reset while idle"}, rst_idle, 0);
  endtask

  // R2: start while busy is ignored
  task automatic t_run_with_extra_start();
    clear_monitor();
    pulse_start();
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    repeat (5) @(negedge clk);
    check(periph_rst == 1'b1, "R4 hold in progress", periph_rst, 1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();
    check_run("run1");
  endtask

  // R9: restart from the done state
  task automatic t_restart();
    clear_monitor();
    pulse_start();
    check(done == 1'b0, "R9 done cleared", done, 0);
    check(busy == 1'b1, "R9 busy again", busy, 1);
    wait_done();
    check_run("run2");
  endtask

  initial begin
    t_reset_state();
    t_run_with_extra_start();
    t_restart();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule